// File: doc/BRIEF.md
# Extended Effective Address Calculator

This block turns one operand addressing request into a final 32-bit operand address. A request names an addressing mode and carries a base register value, the program counter, an index register value, and base and outer displacements, each with a size code. The block picks the base, sign-extends the displacements, and sizes and scales the index. For the two memory-indirect modes it reads one long-word pointer through a read port and adds the remaining terms to the returned pointer. For the postincrement and predecrement modes it also returns the updated register value, which the caller writes back.

Requests enter on a valid/ready port. `cmd_ready` is high only when the block is idle, and a request is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. The read port is valid/ready on the request side. Once `mem_req_valid` is raised it stays high with a fixed address until `mem_req_ready` takes it. The response is a single-cycle `mem_rsp_valid` strobe with no back-pressure. The result port is valid/ready. `res_valid` and every result field stay fixed until `res_ready` takes them, and no new request is taken until then.

Top module: `ea_calc`

## Requirements
- R1: After reset, `cmd_ready` is 1, and `res_valid` and `mem_req_valid` are 0.
- R2: The base is `cmd_pc` when `cmd_pc_sel` is 1 and `cmd_areg` otherwise. It is zero when `cmd_base_sup` is 1.
- R3: The base and outer displacement size codes are 0 = absent (zero), 1 = low 8 bits sign-extended, 2 = low 16 bits sign-extended, and 3 = all 32 bits.
- R4: The index is the low 16 bits of `cmd_idx` sign-extended when `cmd_idx_long` is 0, and all 32 bits when it is 1. It is shifted left by `cmd_idx_scale` (0..3, meaning ×1, ×2, ×4, ×8). It contributes zero when `cmd_idx_sup` is 1.
- R5: In mode 1 (postincrement), the address is the base and the write-back value is the base plus the step. The step is 1, 2 or 4 for `cmd_opsz` 0, 1, or 2/3. `res_wb_en` is 1.
- R6: In mode 2 (predecrement), both the address and the write-back value are the base minus the step, and `res_wb_en` is 1.
- R7: The direct modes issue no memory read, and `res_valid` rises on the cycle after the request is taken. Mode 0 (and 7) gives the base, ignoring displacement and index. Mode 3 gives base + base displacement. Mode 4 gives base + base displacement + index. `res_wb_en` is 0 in every mode except 1 and 2.
- R8: In mode 6 (preindexed indirect), the pointer is read from base + base displacement + index. The address is the pointer + outer displacement.
- R9: In mode 5 (postindexed indirect), the pointer is read from base + base displacement. The address is the pointer + index + outer displacement.
- R10: Each indirect request makes exactly one read. Its valid and address stay stable until `mem_req_ready`.
- R11: `res_valid`, `res_addr`, `res_wb` and `res_wb_en` hold until `res_ready`. `cmd_ready` stays low from acceptance until the result is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Block idle, request taken |
| cmd_mode | input | 3 | Addressing mode code |
| cmd_pc_sel | input | 1 | Use program counter as base |
| cmd_base_sup | input | 1 | Base contributes zero |
| cmd_areg | input | 32 | Address register value |
| cmd_pc | input | 32 | Program counter value |
| cmd_idx | input | 32 | Index register value |
| cmd_idx_long | input | 1 | Index used as full long word |
| cmd_idx_scale | input | 2 | Index shift amount |
| cmd_idx_sup | input | 1 | Index contributes zero |
| cmd_bd | input | 32 | Base displacement raw bits |
| cmd_bd_size | input | 2 | Base displacement size code |
| cmd_od | input | 32 | Outer displacement raw bits |
| cmd_od_size | input | 2 | Outer displacement size code |
| cmd_opsz | input | 2 | Operand size for step |
| mem_req_valid | output | 1 | Pointer read request |
| mem_req_ready | input | 1 | Read request taken |
| mem_req_addr | output | 32 | Pointer read address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Pointer value read |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result taken |
| res_addr | output | 32 | Final operand address |
| res_wb | output | 32 | Register write-back value |
| res_wb_en | output | 1 | Write-back valid |

## Verification
Each displacement size is tried with raw values whose sign bit sits at the cut point, so a wrong sign extension or a wrong width shows as a distinct address. Word and long index values with every scale, and with suppression, separate errors in sizing, shifting and zeroing. The two indirect modes use the same terms but expect different fetch addresses and final sums, which shows whether the index lands before or after the pointer. Read-port stalls, response latency and a held-off result port test that the handshakes keep their values.

// File: rtl/ea_calc_pkg.sv
package ea_calc_pkg;

  typedef enum logic [2:0] {
    AM_IND     = 3'd0,
    AM_POSTINC = 3'd1,
    AM_PREDEC  = 3'd2,
    AM_DISP    = 3'd3,
    AM_INDEX   = 3'd4,
    AM_MEMPOST = 3'd5,
    AM_MEMPRE  = 3'd6,
    AM_RSVD    = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    DSZ_NONE = 2'd0,
    DSZ_BYTE = 2'd1,
    DSZ_WORD = 2'd2,
    DSZ_LONG = 2'd3
  } dsz_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } st_e;

  function automatic logic mode_indirect(input logic [2:0] m);
    return (m == AM_MEMPOST) || (m == AM_MEMPRE);
  endfunction

endpackage

// File: rtl/ea_calc_ext.sv
module ea_calc_ext
  import ea_calc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] raw,
  input  logic [1:0]    size,
  output logic [AW-1:0] value
);
  localparam int BYTE_PAD = AW - 8;
  localparam int WORD_PAD = AW - 16;

  always_comb begin
    case (size)
      DSZ_BYTE: value = {{BYTE_PAD{raw[7]}}, raw[7:0]};
      DSZ_WORD: value = {{WORD_PAD{raw[15]}}, raw[15:0]};
      DSZ_LONG: value = raw;
      default:  value = '0;
    endcase
  end
endmodule

// File: rtl/ea_calc_index.sv
module ea_calc_index #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] raw,
  input  logic          is_long,
  input  logic [1:0]    scale,
  input  logic          sup,
  output logic [AW-1:0] scaled
);
  localparam int WORD_PAD = AW - 16;

  logic [AW-1:0] sized;

  always_comb begin
    sized  = is_long ? raw : {{WORD_PAD{raw[15]}}, raw[15:0]};
    scaled = sup ? '0 : (sized << scale);
  end
endmodule

// File: rtl/ea_calc_fsm.sv
module ea_calc_fsm
  import ea_calc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_indirect,
  input  logic mem_req_ready,
  input  logic mem_rsp_valid,
  input  logic res_ready,
  output logic cmd_ready,
  output logic mem_req_valid,
  output logic ptr_load,
  output logic res_valid
);
  st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (cmd_valid) state_d = cmd_indirect ? ST_REQ : ST_DONE;
      ST_REQ:  if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT: if (mem_rsp_valid) state_d = ST_DONE;
      ST_DONE: if (res_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign cmd_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_REQ);
  assign ptr_load      = (state_q == ST_WAIT) && mem_rsp_valid;
  assign res_valid     = (state_q == ST_DONE);

  AST_REQ_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid); // R10
  AST_RES_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && !cmd_ready); // R11
  AST_DIRECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && !cmd_indirect |=> res_valid); // R7
  AST_INDIRECT_REQUESTS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_indirect |=> mem_req_valid); // R10
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_calc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_mode,
  input  logic          cmd_pc_sel,
  input  logic          cmd_base_sup,
  input  logic [AW-1:0] cmd_areg,
  input  logic [AW-1:0] cmd_pc,
  input  logic [AW-1:0] cmd_idx,
  input  logic          cmd_idx_long,
  input  logic [1:0]    cmd_idx_scale,
  input  logic          cmd_idx_sup,
  input  logic [AW-1:0] cmd_bd,
  input  logic [1:0]    cmd_bd_size,
  input  logic [AW-1:0] cmd_od,
  input  logic [1:0]    cmd_od_size,
  input  logic [1:0]    cmd_opsz,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [AW-1:0] res_addr,
  output logic [AW-1:0] res_wb,
  output logic          res_wb_en
);
  localparam int NDISP = 2;

  logic [2:0]    mode_q;
  logic [AW-1:0] base_q, idx_q, ptr_q;
  logic          idx_long_q, idx_sup_q;
  logic [1:0]    idx_scale_q, opsz_q;
  logic [AW-1:0] disp_raw_q [NDISP];
  logic [1:0]    disp_size_q [NDISP];
  logic [AW-1:0] disp_val [NDISP];
  logic [AW-1:0] idx_val, bd_val, od_val, step, fetch_addr;
  logic          cmd_fire, ptr_load;

  assign cmd_fire = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= AM_IND;
      base_q      <= '0;
      idx_q       <= '0;
      idx_long_q  <= 1'b0;
      idx_sup_q   <= 1'b0;
      idx_scale_q <= '0;
      opsz_q      <= '0;
      for (int i = 0; i < NDISP; i++) begin
        disp_raw_q[i]  <= '0;
        disp_size_q[i] <= DSZ_NONE;
      end
    end else if (cmd_fire) begin
      mode_q         <= cmd_mode;
      base_q         <= cmd_base_sup ? '0 : (cmd_pc_sel ? cmd_pc : cmd_areg);
      idx_q          <= cmd_idx;
      idx_long_q     <= cmd_idx_long;
      idx_sup_q      <= cmd_idx_sup;
      idx_scale_q    <= cmd_idx_scale;
      opsz_q         <= cmd_opsz;
      disp_raw_q[0]  <= cmd_bd;
      disp_size_q[0] <= cmd_bd_size;
      disp_raw_q[1]  <= cmd_od;
      disp_size_q[1] <= cmd_od_size;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (ptr_load) ptr_q <= mem_rsp_data;
  end

  for (genvar g = 0; g < NDISP; g++) begin : g_disp
    ea_calc_ext #(.AW(AW)) u_ext (
      .raw   (disp_raw_q[g]),
      .size  (disp_size_q[g]),
      .value (disp_val[g])
    );
  end

  assign bd_val = disp_val[0];
  assign od_val = disp_val[1];

  ea_calc_index #(.AW(AW)) u_index (
    .raw     (idx_q),
    .is_long (idx_long_q),
    .scale   (idx_scale_q),
    .sup     (idx_sup_q),
    .scaled  (idx_val)
  );

  ea_calc_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid     (cmd_valid),
    .cmd_indirect  (mode_indirect(cmd_mode)),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .res_ready     (res_ready),
    .cmd_ready     (cmd_ready),
    .mem_req_valid (mem_req_valid),
    .ptr_load      (ptr_load),
    .res_valid     (res_valid)
  );

  always_comb begin
    case (opsz_q)
      2'd0:    step = AW'(1);
      2'd1:    step = AW'(2);
      default: step = AW'(4);
    endcase
  end

  assign fetch_addr   = base_q + bd_val + ((mode_q == AM_MEMPRE) ? idx_val : '0);
  assign mem_req_addr = fetch_addr;

  always_comb begin
    res_wb    = base_q;
    res_wb_en = 1'b0;
    case (mode_q)
      AM_POSTINC: begin
        res_addr  = base_q;
        res_wb    = base_q + step;
        res_wb_en = 1'b1;
      end
      AM_PREDEC: begin
        res_addr  = base_q - step;
        res_wb    = base_q - step;
        res_wb_en = 1'b1;
      end
      AM_DISP:    res_addr = base_q + bd_val;
      AM_INDEX:   res_addr = base_q + bd_val + idx_val;
      AM_MEMPOST: res_addr = ptr_q + idx_val + od_val;
      AM_MEMPRE:  res_addr = ptr_q + od_val;
      default:    res_addr = base_q;
    endcase
  end

  AST_REQ_ONLY_INDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mode_q == AM_MEMPOST || mode_q == AM_MEMPRE)); // R7
  AST_REQ_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> $stable(mem_req_addr)); // R10
  AST_RES_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> $stable(res_addr) && $stable(res_wb) && $stable(res_wb_en)); // R11
  AST_PREDEC_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && mode_q == AM_PREDEC |-> res_addr == res_wb); // R6
endmodule

// File: tb/ea_calc_test.sv
`timescale 1ns/1ps
module ea_calc_test;
  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        cmd_valid = 0, cmd_ready;
  logic [2:0]  cmd_mode = 0;
  logic        cmd_pc_sel = 0, cmd_base_sup = 0, cmd_idx_long = 0, cmd_idx_sup = 0;
  logic [31:0] cmd_areg = 0, cmd_pc = 0, cmd_idx = 0, cmd_bd = 0, cmd_od = 0;
  logic [1:0]  cmd_idx_scale = 0, cmd_bd_size = 0, cmd_od_size = 0, cmd_opsz = 0;
  logic        mem_req_valid, mem_req_ready = 0, mem_rsp_valid = 0;
  logic [31:0] mem_req_addr, mem_rsp_data = 0;
  logic        res_valid, res_ready = 1, res_wb_en;
  logic [31:0] res_addr, res_wb;

  int n_chk = 0, n_bad = 0;
  int req_count = 0, stall_cfg = 0, lat_cfg = 0, cnt = 0;
  bit pend = 0;
  logic [31:0] paddr = 0, last_req = 0;

  ea_calc uut (.*);

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h0F0F_0000;
  endfunction

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_fn(paddr);
        pend = 0;
      end else cnt--;
    end
    mem_req_ready = 1'b0;
    if (mem_req_valid && !pend) begin
      if (stall_cfg > 0) stall_cfg--;
      else begin
        mem_req_ready = 1'b1;
        pend = 1; cnt = lat_cfg; paddr = mem_req_addr; last_req = mem_req_addr;
        req_count++;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] mode, input logic psel, input logic bsup,
                       input logic [31:0] areg, input logic [31:0] pc,
                       input logic [31:0] idx, input logic ilong, input logic [1:0] iscale,
                       input logic isup, input logic [31:0] bd, input logic [1:0] bdsz,
                       input logic [31:0] od, input logic [1:0] odsz, input logic [1:0] opsz);
    @(negedge clk);
    cmd_mode = mode; cmd_pc_sel = psel; cmd_base_sup = bsup; cmd_areg = areg; cmd_pc = pc;
    cmd_idx = idx; cmd_idx_long = ilong; cmd_idx_scale = iscale; cmd_idx_sup = isup;
    cmd_bd = bd; cmd_bd_size = bdsz; cmd_od = od; cmd_od_size = odsz; cmd_opsz = opsz;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish(input string tag, input logic [31:0] eaddr, input logic [31:0] ewb,
                        input logic ewben, input int nreq0, input int enreq,
                        input logic [31:0] efetch, input int hold);
    int waited = 0;
    while (!res_valid && waited < 60) begin @(negedge clk); waited++; end
    check({tag, " res_valid"}, 32'(res_valid), 32'd1);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R11 hold valid", 32'(res_valid), 32'd1);
      check("R11 hold addr", res_addr, eaddr);
      check("R11 cmd_ready low", 32'(cmd_ready), 32'd0);
    end
    check({tag, " addr"}, res_addr, eaddr);
    check({tag, " wb_en"}, 32'(res_wb_en), 32'(ewben));
    if (ewben) check({tag, " wb"}, res_wb, ewb);
    check({tag, " R10 read count"}, 32'(req_count - nreq0), 32'(enreq));
    if (enreq != 0) check({tag, " fetch addr"}, last_req, efetch);
    res_ready = 1'b1;
    @(negedge clk);
    check({tag, " R11 released"}, {31'd0, res_valid}, 32'd0);
    check({tag, " R11 ready back"}, 32'(cmd_ready), 32'd1);
  endtask

  task automatic t_reset;
    check("R1 cmd_ready", 32'(cmd_ready), 32'd1);
    check("R1 res_valid", 32'(res_valid), 32'd0);
    check("R1 mem_req_valid", 32'(mem_req_valid), 32'd0);
  endtask

  task automatic t_base;
    int n0 = req_count;
    issue(3'd0, 0, 0, 32'h1000, 32'h9999_0000, 32'd5, 1, 2'd0, 0, 32'h44, 2'd3, 32'h10, 2'd3, 2'd0);
    finish("R7 plain ignores terms", 32'h1000, 0, 0, n0, 0, 0, 0);
    n0 = req_count;
    issue(3'd0, 1, 0, 32'h1000, 32'h2000_0000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    finish("R2 pc base", 32'h2000_0000, 0, 0, n0, 0, 0, 0);
    n0 = req_count;
    issue(3'd3, 1, 1, 32'h1000, 32'h2000_0000, 0, 0, 0, 0, 32'h40, 2'd3, 0, 0, 0);
    finish("R2 suppressed base", 32'h40, 0, 0, n0, 0, 0, 0);
  endtask

  task automatic t_disp;
    int n0 = req_count;
    issue(3'd3, 0, 0, 32'h1000, 0, 0, 0, 0, 0, 32'h0000_0080, 2'd1, 0, 0, 0);
    finish("R3 byte disp", 32'h0000_0F80, 0, 0, n0, 0, 0, 0);
    n0 = req_count;
    issue(3'd3, 0, 0, 32'h0010_0000, 0, 0, 0, 0, 0, 32'h0001_8000, 2'd2, 0, 0, 0);
    finish("R3 word disp", 32'h000F_8000, 0, 0, n0, 0, 0, 0);
    n0 = req_count;
    issue(3'd3, 0, 0, 32'h10, 0, 0, 0, 0, 0, 32'h1234_0000, 2'd3, 0, 0, 0);
    finish("R3 long disp", 32'h1234_0010, 0, 0, n0, 0, 0, 0);
    n0 = req_count;
    issue(3'd3, 0, 0, 32'h500, 0, 0, 0, 0, 0, 32'h0000_FFFF, 2'd0, 0, 0, 0);
    finish("R3 absent disp", 32'h500, 0, 0, n0, 0, 0, 0);
  endtask

  task automatic t_index;
    int n0 = req_count;
    issue(3'd4, 0, 0, 32'h1000, 0, 32'h0000_FFFE, 0, 2'd2, 0, 32'h10, 2'd1, 0, 0, 0);
    finish("R4 word index x4", 32'h1008, 0, 0, n0, 0, 0, 0);
    n0 = req_count;
    issue(3'd4, 0, 0, 32'h1000, 0, 32'h0001_0000, 1, 2'd3, 0, 32'h10, 2'd1, 0, 0, 0);
    finish("R4 long index x8", 32'h0008_1010, 0, 0, n0, 0, 0, 0);
    n0 = req_count;
    issue(3'd4, 0, 0, 32'h1000, 0, 32'h0001_0000, 1, 2'd3, 1, 32'h10, 2'd1, 0, 0, 0);
    finish("R4 suppressed index", 32'h1010, 0, 0, n0, 0, 0, 0);
    n0 = req_count;
    issue(3'd4, 1, 0, 32'h1000, 32'h4000, 32'd3, 1, 2'd1, 0, 32'h0100, 2'd2, 0, 0, 0);
    finish("R4 pc index x2", 32'h4106, 0, 0, n0, 0, 0, 0);
  endtask

  task automatic t_incdec;
    int n0 = req_count;
    issue(3'd1, 0, 0, 32'h3000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0);
    finish("R5 postinc byte", 32'h3000, 32'h3001, 1, n0, 0, 0, 0);
    n0 = req_count;
    issue(3'd1, 0, 0, 32'h3000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd1);
    finish("R5 postinc word", 32'h3000, 32'h3002, 1, n0, 0, 0, 0);
    n0 = req_count;
    issue(3'd1, 0, 0, 32'h3000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd3);
    finish("R5 postinc long", 32'h3000, 32'h3004, 1, n0, 0, 0, 0);
    n0 = req_count;
    issue(3'd2, 0, 0, 32'h3000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd2);
    finish("R6 predec long", 32'h2FFC, 32'h2FFC, 1, n0, 0, 0, 0);
    n0 = req_count;
    issue(3'd2, 0, 0, 32'h3000, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd0);
    finish("R6 predec byte", 32'h2FFF, 32'h2FFF, 1, n0, 0, 0, 0);
  endtask

  task automatic t_mem_pre;
    int n0 = req_count;
    stall_cfg = 1; lat_cfg = 2;
    issue(3'd6, 0, 0, 32'h0001_0000, 0, 32'h0000_0004, 0, 2'd2, 0, 32'h20, 2'd2, 32'h0000_FFF0, 2'd2, 0);
    finish("R8 preindexed", mem_fn(32'h0001_0030) - 32'h10, 0, 0, n0, 1, 32'h0001_0030, 0);
  endtask

  task automatic t_mem_post;
    int n0 = req_count;
    stall_cfg = 3; lat_cfg = 4;
    issue(3'd5, 0, 0, 32'h0002_0000, 0, 32'h8, 1, 2'd1, 0, 32'h100, 2'd3, 32'h1000_0000, 2'd3, 0);
    finish("R9 postindexed", mem_fn(32'h0002_0100) + 32'h10 + 32'h1000_0000, 0, 0, n0, 1, 32'h0002_0100, 0);
    n0 = req_count;
    stall_cfg = 0; lat_cfg = 0;
    issue(3'd5, 1, 0, 0, 32'h8000, 32'h8, 1, 2'd1, 1, 32'h0, 2'd0, 32'h5, 2'd0, 0);
    finish("R9 pc postindexed bare", mem_fn(32'h8000), 0, 0, n0, 1, 32'h8000, 0);
  endtask

  task automatic t_backpressure;
    int n0 = req_count;
    res_ready = 1'b0;
    stall_cfg = 0; lat_cfg = 1;
    issue(3'd6, 0, 0, 32'h0000_4000, 0, 32'h2, 1, 2'd0, 0, 32'h0, 2'd0, 32'h4, 2'd1, 0);
    finish("R11 held result", mem_fn(32'h0000_4002) + 32'h4, 0, 0, n0, 1, 32'h0000_4002, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_base;
    t_disp;
    t_index;
    t_incdec;
    t_mem_pre;
    t_mem_post;
    t_backpressure;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule